// File: doc/BRIEF.md
# Additive Fibonacci Checksum with Wrap-Around Carry

This block computes a running checksum over a stream of 16-bit words, taking one word per clock. It holds two running registers, a 17-bit `X` and a 16-bit `Y`, plus a 2-bit carry accumulator `C`. Every accepted word advances a Fibonacci-like recurrence. The word is mixed in by addition, and the carry produced by each step is fed back into the next step.

Mixing by addition lets `X` reach 1FFFEh, so it must be 17 bits wide. As a result, the sum that feeds `Y` can be as large as 2FFFDh. The carry carried forward is therefore one of 0, 1 or 2 rather than a single bit.

A user pulses `start_i` to clear the state and then presents words with `valid_i`, marking the final word with `last_i`. One cycle after that word is absorbed, `done_o` is high and the three signature outputs show the raw internal state. Reducing the signature to 16 bits is left to logic outside this block.

Top module: `eac_fib_checksum`

## Requirements
- R1: After reset, `sig_x_o`, `sig_y_o` and `sig_c_o` are all zero and `done_o` is low.
- R2: A cycle with `start_i` high clears X, Y and C to zero. It takes priority over a word presented with `valid_i` in the same cycle: that word is discarded and raises no `done_o`.
- R3: On a cycle with both `valid_i` and `start_i` low, X, Y and C keep their values.
- R4: An accepted word sets X to the Y value from before that step plus the word, kept as a full 17-bit result with no truncation.
- R5: An accepted word forms S = C + X + Y from the pre-step values. Y takes S bits 15..0 and C takes S bits 17..16, so C never exceeds 2.
- R6: After a clear, four words of FFFFh leave X = 1FFFDh, Y = FFFDh and C = 2.
- R7: `done_o` is high for exactly the one cycle after an accepted word that had `last_i` high, and is low at all other times.
- R8: In the cycle where `done_o` is high, the signature outputs show the state that includes the last word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Clears the state; wins over `valid_i` |
| valid_i | input | 1 | `data_i` holds a word to absorb |
| data_i | input | 16 | Message word |
| last_i | input | 1 | Marks the final word of a message |
| done_o | output | 1 | One-cycle flag: signature complete |
| sig_x_o | output | 17 | Register X |
| sig_y_o | output | 16 | Register Y |
| sig_c_o | output | 2 | Carry accumulator C |

## Verification
Every result of this block lives exactly one register away from its inputs. The word presented at a rising edge shows up in X, Y and C at that same edge, and `done_o` rises at that edge and falls at the next. The bench therefore drives inputs on falling edges and reads all outputs on the falling edge that follows the absorbing rising edge. The same rule applies to clears and idle cycles, so every check lands in the single cycle where its result is due.

// File: rtl/eac_pkg.sv
package eac_pkg;
   localparam int WORD_W  = 16;
   localparam int CARRY_W = 2;

   // Bits required to hold a value up to and including max_v.
   function automatic int bits_for(input int max_v);
      int n;
      n = 1;
      while ((1 << n) <= max_v) n++;
      return n;
   endfunction
endpackage

// File: rtl/eac_step.sv
// Combinational next-state for a single absorbed word.
module eac_step #(
   parameter int W  = eac_pkg::WORD_W,
   parameter int CW = eac_pkg::CARRY_W,
   localparam int XW = W + 1,
   localparam int SW = W + CW
) (
   input  logic [XW-1:0] x_i,
   input  logic [W-1:0]  y_i,
   input  logic [CW-1:0] c_i,
   input  logic [W-1:0]  word_i,
   output logic [XW-1:0] x_o,
   output logic [W-1:0]  y_o,
   output logic [CW-1:0] c_o
);
   // Upper bound of C + X + Y is (2^W - 1)*3 + 2.
   localparam int S_MAX_BITS = eac_pkg::bits_for(3);

   generate
      if (W < 2) begin : g_bad_width
         $error("eac_step: W must be at least 2");
      end
      if (CW < S_MAX_BITS) begin : g_bad_carry
         $error("eac_step: carry field too narrow for a three-way sum");
      end
   endgenerate

   logic [SW-1:0] sum;

   always_comb begin
      sum = {{(SW-XW){1'b0}}, x_i}
          + {{(SW-W){1'b0}}, y_i}
          + {{(SW-CW){1'b0}}, c_i};
      // The new X uses the Y value that was current before this step.
      x_o = {1'b0, y_i} + {1'b0, word_i};
      y_o = sum[W-1:0];
      c_o = sum[SW-1:W];
   end
endmodule

// File: rtl/eac_regs.sv
// State registers with clear, load and hold.
module eac_regs #(
   parameter int W  = eac_pkg::WORD_W,
   parameter int CW = eac_pkg::CARRY_W,
   localparam int XW = W + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          load_i,
   input  logic [W-1:0]  word_i,
   input  logic [XW-1:0] x_nxt_i,
   input  logic [W-1:0]  y_nxt_i,
   input  logic [CW-1:0] c_nxt_i,
   output logic [XW-1:0] x_q,
   output logic [W-1:0]  y_q,
   output logic [CW-1:0] c_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x_q <= '0;
         y_q <= '0;
         c_q <= '0;
      end else if (clr_i) begin
         x_q <= '0;
         y_q <= '0;
         c_q <= '0;
      end else if (load_i) begin
         x_q <= x_nxt_i;
         y_q <= y_nxt_i;
         c_q <= c_nxt_i;
      end
   end

   assert_c_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
      c_q <= CW'(2));

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (x_q == '0 && y_q == '0 && c_q == '0));

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !load_i) |=> ($stable(x_q) && $stable(y_q) && $stable(c_q)));

   assert_x_old_y_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && !clr_i) |=> (x_q == ({1'b0, $past(y_q)} + {1'b0, $past(word_i)})));
endmodule

// File: rtl/eac_done_ctl.sv
// Accept decode and end-of-message flag.
module eac_done_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic valid_i,
   input  logic last_i,
   output logic clr_o,
   output logic load_o,
   output logic done_o
);
   always_comb begin
      clr_o  = start_i;
      load_o = valid_i && !start_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_o <= 1'b0;
      else        done_o <= valid_i && !start_i && last_i;
   end

   assert_done_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(valid_i && last_i && !start_i));

   assert_done_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && last_i && !start_i) |=> done_o);
endmodule

// File: rtl/eac_fib_checksum.sv
module eac_fib_checksum #(
   parameter int W  = eac_pkg::WORD_W,
   parameter int CW = eac_pkg::CARRY_W,
   localparam int XW = W + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          valid_i,
   input  logic [W-1:0]  data_i,
   input  logic          last_i,
   output logic          done_o,
   output logic [XW-1:0] sig_x_o,
   output logic [W-1:0]  sig_y_o,
   output logic [CW-1:0] sig_c_o
);
   logic          clr, load;
   logic [XW-1:0] x_q, x_nxt;
   logic [W-1:0]  y_q, y_nxt;
   logic [CW-1:0] c_q, c_nxt;

   eac_done_ctl u_ctl (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(valid_i),
      .last_i(last_i), .clr_o(clr), .load_o(load), .done_o(done_o)
   );

   eac_step #(.W(W), .CW(CW)) u_step (
      .x_i(x_q), .y_i(y_q), .c_i(c_q), .word_i(data_i),
      .x_o(x_nxt), .y_o(y_nxt), .c_o(c_nxt)
   );

   eac_regs #(.W(W), .CW(CW)) u_regs (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .load_i(load), .word_i(data_i),
      .x_nxt_i(x_nxt), .y_nxt_i(y_nxt), .c_nxt_i(c_nxt),
      .x_q(x_q), .y_q(y_q), .c_q(c_q)
   );

   assign sig_x_o = x_q;
   assign sig_y_o = y_q;
   assign sig_c_o = c_q;

   assert_y_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && !start_i) |=>
         ({sig_c_o, sig_y_o} ==
          ({{(CW-1){1'b0}}, $past(sig_x_o)} + {{CW{1'b0}}, $past(sig_y_o)}
           + {{W{1'b0}}, $past(sig_c_o)})));
endmodule

// File: tb/eac_fib_checksum_test.sv
`timescale 1ns/1ps
module eac_fib_checksum_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0, valid_i = 1'b0, last_i = 1'b0;
   logic [15:0] data_i = '0;
   logic        done_o;
   logic [16:0] sig_x_o;
   logic [15:0] sig_y_o;
   logic [1:0]  sig_c_o;

   int tests = 0, fails = 0;
   logic [16:0] mx;
   logic [15:0] my;
   logic [1:0]  mc;

   // Bit 16 = last flag, bits 15..0 = word.
   localparam logic [16:0] VEC [0:11] = '{
      17'h0_1234, 17'h0_FFFF, 17'h0_8000, 17'h1_00A5,
      17'h0_FFFF, 17'h0_FFFF, 17'h0_0001, 17'h0_7FFF,
      17'h0_C3C3, 17'h0_FFFF, 17'h0_0000, 17'h1_BEEF};

   always #2 clk = ~clk;

   eac_fib_checksum uut (.*);

   initial begin
      #400000;
      fails++; tests++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   task automatic model_clear();
      mx = '0; my = '0; mc = '0;
   endtask

   task automatic model_step(input logic [15:0] d);
      longint s;
      s  = longint'(mc) + longint'(mx) + longint'(my);
      mx = {1'b0, my} + {1'b0, d};
      my = s[15:0];
      mc = s[17:16];
   endtask

   task automatic check_sig(input string req);
      tests++;
      if (sig_x_o !== mx || sig_y_o !== my || sig_c_o !== mc) begin
         fails++;
         $display("FAIL %s: actual x=%h y=%h c=%0d expected x=%h y=%h c=%0d",
                  req, sig_x_o, sig_y_o, sig_c_o, mx, my, mc);
      end
   endtask

   task automatic check_done(input string req, input logic exp);
      tests++;
      if (done_o !== exp) begin
         fails++;
         $display("FAIL %s: done actual=%b expected=%b", req, done_o, exp);
      end
   endtask

   // Drive at falling edge, absorb at rising edge, sample at next falling edge.
   task automatic cyc(input logic st, input logic v, input logic [15:0] d, input logic l);
      start_i = st; valid_i = v; data_i = d; last_i = l;
      @(negedge clk);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      model_clear();
      check_sig("R1 reset state");
      check_done("R1 reset done", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // Table walk: R4/R5 per word, R7/R8 at the flagged words.
      cyc(1'b1, 1'b0, 16'h0, 1'b0);
      model_clear();
      check_sig("R2 clear before table");
      for (int i = 0; i < 12; i++) begin
         cyc(1'b0, 1'b1, VEC[i][15:0], VEC[i][16]);
         model_step(VEC[i][15:0]);
         check_sig(VEC[i][16] ? "R8 signature at done" : "R4 R5 step");
         check_done("R7 done timing", VEC[i][16]);
      end
      cyc(1'b0, 1'b0, 16'h0, 1'b0);
      check_done("R7 done one cycle", 1'b0);

      // R3: idle cycles with junk on data/last hold everything.
      cyc(1'b0, 1'b0, 16'hAAAA, 1'b1);
      cyc(1'b0, 1'b0, 16'h5555, 1'b1);
      check_sig("R3 hold on idle");
      check_done("R3 no done on idle", 1'b0);

      // R2: start with a valid last word: word discarded, no done.
      cyc(1'b1, 1'b1, 16'hFFFF, 1'b1);
      model_clear();
      check_sig("R2 start wins over valid");
      check_done("R2 no done with start", 1'b0);

      // R6: four FFFFh words reach the maximum carry.
      for (int i = 0; i < 4; i++) begin
         cyc(1'b0, 1'b1, 16'hFFFF, i == 3);
         model_step(16'hFFFF);
      end
      tests++;
      if (sig_x_o !== 17'h1FFFD || sig_y_o !== 16'hFFFD || sig_c_o !== 2'd2) begin
         fails++;
         $display("FAIL R6: actual x=%h y=%h c=%0d expected x=1fffd y=fffd c=2",
                  sig_x_o, sig_y_o, sig_c_o);
      end
      check_sig("R6 model agrees");
      check_done("R7 done after all-ones", 1'b1);

      // Longer all-ones run: C must stay within 0..2 and track the model.
      for (int i = 0; i < 40; i++) begin
         cyc(1'b0, 1'b1, 16'hFFFF, 1'b0);
         model_step(16'hFFFF);
         check_sig("R5 all-ones carry");
      end

      // Pseudo-random message with idle gaps.
      begin
         logic [15:0] lf;
         lf = 16'hACE1;
         cyc(1'b1, 1'b0, 16'h0, 1'b0);
         model_clear();
         for (int i = 0; i < 200; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[3]) begin
               cyc(1'b0, 1'b1, lf, i == 199);
               model_step(lf);
            end else begin
               cyc(1'b0, 1'b0, lf, 1'b0);
            end
            check_sig("R4 R5 random");
         end
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule